// File: doc/BRIEF.md
# Indivisible Fetch-and-Op Memory Unit

This unit sits in front of one bank of word storage and carries out indivisible read-modify-write requests. A request carries an opcode, a word address, an operand and a requester tag. In the cycle the request is accepted, the unit reads the current word, combines it with the operand through the combining function the opcode selects, writes the result back, and registers a reply. The reply holds the prior word, or a value derived from it, together with the unchanged tag.

Plain loads, plain stores, swaps and test-and-set do not have their own paths. Each is a member of one fetch-and-combine family, and all of them share one datapath that has a single read, a single combine and a single write. Because the read and the write of a word happen in the same stage, a request arriving in the very next cycle already sees the updated word. Several operations on one location therefore behave as if they ran one after another in the order of acceptance. The storage is an internal register array.

Top module: `fop_unit`

## Requirements
- R1: While reset is held and after reset releases, `rsp_valid` is low. Every word of the bank holds zero after reset.
- R2: Opcode 2 (add) replies with the prior word and leaves prior word plus operand in the location. The sum wraps modulo 2^DATA_W and no overflow indication exists.
- R3: Opcode 0 (load) replies with the prior word and leaves the location unchanged. The operand has no effect.
- R4: Opcode 1 (store) writes the operand into the location and replies with data zero.
- R5: Opcode 3 (swap) writes the operand into the location and replies with the prior word.
- R6: Opcode 4 (test-and-set) sets every bit of the location to one. It replies with 1 in bit 0 if the prior word was nonzero and 0 if it was zero, and all other reply bits are zero.
- R7: Opcodes 5, 6 and 7 behave exactly as a load: the prior word is returned and nothing is written.
- R8: The unit accepts one request per cycle. A request accepted in the cycle right after another one to the same address observes that earlier request's result, so consecutive adds return the running partial sums.
- R9: Each accepted request produces exactly one reply, which is valid in the cycle after acceptance and carries the request's tag unchanged.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, the reply holds steady, and a pending request changes no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_op | input | 3 | Opcode: 0 load, 1 store, 2 add, 3 swap, 4 test-and-set |
| req_addr | input | ADDR_W | Word address |
| req_operand | input | DATA_W | Operand for the combining function |
| req_tag | input | TAG_W | Requester tag, echoed in the reply |
| rsp_valid | output | 1 | Reply present |
| rsp_ready | input | 1 | Requester takes the reply |
| rsp_data | output | DATA_W | Prior word or value derived from it |
| rsp_tag | output | TAG_W | Tag of the request being answered |

## Verification
The hardest situation to reach from the ports is a request that waits at the input while a reply is stalled. This case has to show that the waiting request neither commits early nor commits twice once the reply drains. The stimulus lowers `rsp_ready`, holds a second add to the same word at the input for a cycle, and then releases it. The reply value and a later load of the word show whether the stalled cycle left the word untouched. Dense back-to-back add bursts to one word cover the serial-order behaviour, because each reply must equal the prefix sum in acceptance order.

// File: rtl/fop_pkg.sv
package fop_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_ADD   = 3'd2,
    OP_SWAP  = 3'd3,
    OP_TAS   = 3'd4
  } fop_op_e;

endpackage

// File: rtl/fop_bank.sv
module fop_bank #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        mem_q[i] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(i))) begin
        mem_q[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R8: a write is visible to a read of the same word in the next cycle
  a_r8_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && (rd_addr == $past(wr_addr)) && !$past(!rst_n))
      |-> (rd_data == $past(wr_data)));

endmodule

// File: rtl/fop_alu.sv
module fop_alu
  import fop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fop_op_e           op,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] new_word,
  output logic [DATA_W-1:0] reply_word,
  output logic              wr_en
);

  function automatic logic [DATA_W-1:0] phi_fn(fop_op_e f, logic [DATA_W-1:0] a,
                                                logic [DATA_W-1:0] b);
    case (f)
      OP_ADD:            return a + b;
      OP_STORE, OP_SWAP: return b;
      OP_TAS:            return a | {DATA_W{1'b1}};
      default:           return a;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] reply_fn(fop_op_e f, logic [DATA_W-1:0] a);
    logic [DATA_W-1:0] r;
    r = a;
    if (f == OP_STORE) begin
      r = '0;
    end else if (f == OP_TAS) begin
      r    = '0;
      r[0] = |a;
    end
    return r;
  endfunction

  function automatic logic writes_fn(fop_op_e f);
    case (f)
      OP_STORE, OP_ADD, OP_SWAP, OP_TAS: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

  assign new_word   = phi_fn(op, old_word, operand);
  assign reply_word = reply_fn(op, old_word);
  assign wr_en      = writes_fn(op);

endmodule

// File: rtl/fop_reply.sv
module fop_reply #(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] in_data,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              can_accept
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic [TAG_W-1:0]  tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      tag_q   <= '0;
    end else begin
      if (load) begin
        valid_q <= 1'b1;
        data_q  <= in_data;
        tag_q   <= in_tag;
      end else if (rsp_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_data   = data_q;
  assign rsp_tag    = tag_q;
  assign can_accept = !valid_q || rsp_ready;

  // R10: a stalled reply keeps its contents until taken
  a_r10_reply_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_tag)));

endmodule

// File: rtl/fop_unit.sv
module fop_unit
  import fop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_operand,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag
);

  // Named internal events
  logic              acc_fire;
  logic              slot_free;
  logic [DATA_W-1:0] bank_rd;
  logic [DATA_W-1:0] alu_new;
  logic [DATA_W-1:0] alu_reply;
  logic              alu_wr;
  logic              commit_wr;
  fop_op_e           op_dec;

  assign op_dec    = fop_op_e'(req_op);
  assign req_ready = slot_free;
  assign acc_fire  = req_valid && slot_free;
  assign commit_wr = acc_fire && alu_wr;

  fop_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (req_addr),
    .rd_data (bank_rd),
    .wr_en   (commit_wr),
    .wr_addr (req_addr),
    .wr_data (alu_new)
  );

  fop_alu #(.DATA_W(DATA_W)) u_alu (
    .op         (op_dec),
    .old_word   (bank_rd),
    .operand    (req_operand),
    .new_word   (alu_new),
    .reply_word (alu_reply),
    .wr_en      (alu_wr)
  );

  fop_reply #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_reply (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (acc_fire),
    .in_data    (alu_reply),
    .in_tag     (req_tag),
    .rsp_ready  (rsp_ready),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .rsp_tag    (rsp_tag),
    .can_accept (slot_free)
  );

  // R9: every accepted request is answered next cycle with its own tag
  a_r9_tag_echo: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_fire) |-> (rsp_valid && (rsp_tag == $past(req_tag))));

  // R10: no new request is taken while a reply is stalled
  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> (!req_ready && !commit_wr));

  // R3, R7: load and unassigned opcodes never write the bank
  a_r3_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && (req_op == 3'd0 || req_op > 3'd4)) |-> !commit_wr);

  // R4: a store answers with zero data
  a_r4_store_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_fire) && ($past(req_op) == 3'd1)) |-> (rsp_data == '0));

  // R6: test-and-set answers with a single boolean bit
  a_r6_tas_bool: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_fire) && ($past(req_op) == 3'd4)) |-> (rsp_data[DATA_W-1:1] == '0));

  // R1: reply channel idle in the first cycle after reset
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(!rst_n) |-> !rsp_valid);

endmodule

// File: tb/test_fop_unit.sv
`timescale 1ns/1ps
module test_fop_unit;

  localparam int DW = 32;
  localparam int AW = 4;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_operand = '0;
  logic [TW-1:0] req_tag = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic [TW-1:0] rsp_tag;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [DW-1:0] shadow [1<<AW];

  always #4 clk = ~clk;

  fop_unit #(.DATA_W(DW), .ADDR_W(AW), .TAG_W(TW)) i_fop_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_operand(req_operand), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_tag(rsp_tag)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench model: written as the requirement text reads
  function automatic logic [DW-1:0] want_reply(logic [2:0] op, logic [DW-1:0] old);
    if (op == 3'd1) return '0;
    if (op == 3'd4) return (old != 0) ? 32'd1 : 32'd0;
    return old;
  endfunction

  function automatic logic [DW-1:0] want_word(logic [2:0] op, logic [DW-1:0] old,
                                               logic [DW-1:0] b);
    if (op == 3'd2) return old + b;
    if (op == 3'd1 || op == 3'd3) return b;
    if (op == 3'd4) return {DW{1'b1}};
    return old;
  endfunction

  task automatic send(string req, logic [2:0] op, logic [AW-1:0] a,
                      logic [DW-1:0] b, logic [TW-1:0] t);
    logic [DW-1:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_operand = b; req_tag = t;
    exp = want_reply(op, shadow[a]);
    shadow[a] = want_word(op, shadow[a], b);
    @(posedge clk); #1;
    chk({req, " valid"}, {31'd0, rsp_valid}, 32'd1);
    chk({req, " data"}, rsp_data, exp);
    chk("R9 tag", {28'd0, rsp_tag}, {28'd0, t});
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", {31'd0, rsp_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 valid after reset", {31'd0, rsp_valid}, 32'd0);
    send("R1 zero word 0", 3'd0, 4'd0, 32'h0, 4'd1);
    send("R1 zero word 5", 3'd0, 4'd5, 32'h0, 4'd2);
    send("R1 zero word 15", 3'd0, 4'd15, 32'h0, 4'd3);
    idle();
  endtask

  task automatic t_add();
    send("R2 add first", 3'd2, 4'd3, 32'd10, 4'd4);
    send("R8 add back-to-back", 3'd2, 4'd3, 32'd5, 4'd5);
    send("R2 load sum", 3'd0, 4'd3, 32'd0, 4'd6);
    send("R4 store max", 3'd1, 4'd4, 32'hFFFF_FFFF, 4'd7);
    send("R2 add wraps", 3'd2, 4'd4, 32'd2, 4'd8);
    send("R2 wrapped word", 3'd0, 4'd4, 32'd0, 4'd9);
    idle();
  endtask

  task automatic t_load();
    send("R3 load ignores operand", 3'd0, 4'd3, 32'hDEAD_BEEF, 4'd10);
    send("R3 location unchanged", 3'd0, 4'd3, 32'h1234_5678, 4'd11);
    idle();
  endtask

  task automatic t_swap();
    send("R5 swap first", 3'd3, 4'd6, 32'hAAAA_0001, 4'd12);
    send("R5 swap second", 3'd3, 4'd6, 32'h5555_0002, 4'd13);
    send("R5 swapped word", 3'd0, 4'd6, 32'd0, 4'd14);
    idle();
  endtask

  task automatic t_tas();
    send("R6 tas on zero", 3'd4, 4'd7, 32'd0, 4'd15);
    send("R6 tas on set", 3'd4, 4'd7, 32'd0, 4'd0);
    send("R6 word all ones", 3'd0, 4'd7, 32'd0, 4'd1);
    send("R4 store for tas", 3'd1, 4'd8, 32'h0000_0100, 4'd2);
    send("R6 tas on nonzero", 3'd4, 4'd8, 32'd9, 4'd3);
    idle();
  endtask

  task automatic t_undef();
    for (int k = 5; k < 8; k++)
      send("R7 unassigned op", 3'(k), 4'd3, 32'h0F0F_0F0F, 4'(k));
    send("R7 word unchanged", 3'd0, 4'd3, 32'd0, 4'd8);
    idle();
  endtask

  task automatic t_burst();
    for (int k = 1; k <= 6; k++)
      send("R8 prefix sum", 3'd2, 4'd9, 32'(k * 3), 4'(k));
    send("R8 total", 3'd0, 4'd9, 32'd0, 4'd7);
    idle();
  endtask

  task automatic t_stall();
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_op = 3'd2; req_addr = 4'd10; req_operand = 32'd7; req_tag = 4'd1;
    @(posedge clk); #1;
    chk("R10 first reply data", rsp_data, 32'd0);
    chk("R10 ready low", {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    req_operand = 32'd100; req_tag = 4'd2;
    @(posedge clk); #1;
    chk("R10 reply held data", rsp_data, 32'd0);
    chk("R10 reply held tag", {28'd0, rsp_tag}, 32'd1);
    @(negedge clk);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    chk("R10 pending reply tag", {28'd0, rsp_tag}, 32'd2);
    chk("R10 pending saw one add", rsp_data, 32'd7);
    shadow[10] = 32'd107;
    idle();
    send("R10 word after stall", 3'd0, 4'd10, 32'd0, 4'd3);
    idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual %0d expected below 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < (1 << AW); k++) shadow[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_add();
    t_load();
    t_swap();
    t_tas();
    t_undef();
    t_burst();
    t_stall();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule